// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Divider

The block divides a fast input clock by a programmable integer N, producing one short pulse per N input cycles, meant to be the feedback input of a digital phase frequency detector. The detector compares that pulse against a divided reference. The division is built the classic pulse-swallow way. A dual-modulus prescaler divides by P or P+1. A main counter counts B prescaler output cycles per period. A swallow counter keeps the prescaler at P+1 for the first A of them. The total is N = P*B + A. P is picked from four powers of two, 8, 16, 32 and 64, by a two-bit select. The swallow field is 6 bits wide and the main field is 12 bits wide.

Settings arrive on three field inputs and are captured by a one-cycle load strobe. A setting is accepted only if B is at least 1 and A does not exceed B. An accepted setting waits in a pending slot and becomes active only at the next period boundary, so no period ever mixes two settings. A rejected setting raises an error flag and changes nothing.

The sequencer is a two-state machine. In state ST_SWALLOW the prescaler divides by P+1. In state ST_MAIN it divides by P. The transition SWALLOW_DONE (ST_SWALLOW to ST_MAIN) is taken on the A-th prescaler tick of a period. The transition PERIOD_WRAP is taken on the B-th tick. It enters ST_SWALLOW when the A of the coming period is non-zero, and ST_MAIN otherwise. Reset enters the state that suits the default A.

Top module: `pulse_swallow_div`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) drives div_pulse and cfg_err low and selects the defaults A=0, B=1, sel=0. The first div_pulse is then high after the 8th rising edge following release of rst, and the period is 8.
- R2: The pulse period is N = P*B + A, where P = 8 << sel, so sel values 0, 1, 2 and 3 give P = 8, 16, 32 and 64. This holds for A=0, for A=B and for maximum fields.
- R3: div_pulse is high for exactly one input cycle per period.
- R4: An accepted load has no effect on the period in progress; the new N applies from the next period boundary on. A load is accepted when cfg_b >= 1 and cfg_a <= cfg_b.
- R5: A rejected load leaves the active setting and any earlier accepted pending setting unchanged. A load is rejected when cfg_b = 0 or cfg_a > cfg_b.
- R6: cfg_err changes only on a load. It is high in the cycle after a rejected load, low in the cycle after an accepted load, and otherwise holds its value.
- R7: When several accepted loads fall within one period, the last one is applied at the boundary.
- R8: A load sampled on the same rising edge that raises div_pulse does not affect the period that then starts. It applies from the period after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures cfg_a, cfg_b and cfg_sel |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 12 | Main count B |
| cfg_sel | input | 2 | Prescaler select: P = 8 << cfg_sel |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | High after a rejected load |

## Verification
On every cycle, the assertions check the following:
- the pulse width;
- the error flag's response to each load and its hold otherwise;
- that the active setting is always legal and never moves except at a period boundary;
- that the sequencer is in the swallow state only while fewer than A prescaler ticks of the period have passed.

Only the bench scenarios can show the actual period lengths for each prescaler select and field pattern. The same holds for the delay before a new setting applies, including a load that coincides with the pulse. The bench scenarios also show that the last of several loads wins and that a rejected load keeps a pending one.

// File: rtl/pss_pkg.sv
package pss_pkg;

    // Sequencer phase within one output period
    typedef enum logic [0:0] {
        ST_SWALLOW = 1'b0,   // prescaler divides by P+1
        ST_MAIN    = 1'b1    // prescaler divides by P
    } phase_t;

    // Field set carried between the configuration gate and the counters
    function automatic logic cfg_legal(input int unsigned a, input int unsigned b);
        return (b != 0) && (a <= b);
    endfunction

endpackage

// File: rtl/pss_cfg_gate.sv
module pss_cfg_gate #(
    parameter int AW      = 6,
    parameter int BW      = 12,
    parameter int SW      = 2,
    parameter int DEF_A   = 0,
    parameter int DEF_B   = 1,
    parameter int DEF_SEL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] in_a,
    input  logic [BW-1:0] in_b,
    input  logic [SW-1:0] in_sel,
    input  logic          period_end,
    output logic [AW-1:0] act_a,
    output logic [BW-1:0] act_b,
    output logic [SW-1:0] act_sel,
    output logic [AW-1:0] nxt_a,
    output logic          cfg_err
);
    import pss_pkg::*;

    logic          pend_valid;
    logic [AW-1:0] pend_a;
    logic [BW-1:0] pend_b;
    logic [SW-1:0] pend_sel;
    logic          in_ok;
    logic          take;

    always_comb begin
        in_ok = cfg_legal(int'(in_a), int'(in_b));
        take  = load && in_ok;
    end

    // Pending slot: a new accepted load always wins over the boundary clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_a     <= '0;
            pend_b     <= '0;
            pend_sel   <= '0;
        end else begin
            if (take) begin
                pend_valid <= 1'b1;
                pend_a     <= in_a;
                pend_b     <= in_b;
                pend_sel   <= in_sel;
            end else if (period_end) begin
                pend_valid <= 1'b0;
            end
        end
    end

    // Active setting moves only at a period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            act_a   <= AW'(DEF_A);
            act_b   <= BW'(DEF_B);
            act_sel <= SW'(DEF_SEL);
        end else if (period_end && pend_valid) begin
            act_a   <= pend_a;
            act_b   <= pend_b;
            act_sel <= pend_sel;
        end
    end

    // Error flag refreshed on every load, held otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else if (load) begin
            cfg_err <= !in_ok;
        end
    end

    always_comb begin
        nxt_a = pend_valid ? pend_a : act_a;
    end

endmodule

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
    parameter int SW        = 2,
    parameter int P_LOG_MIN = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swallow,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int NSEL     = 1 << SW;
    localparam int PMAX_LOG = P_LOG_MIN + NSEL - 1;
    localparam int PCW      = PMAX_LOG + 1;

    logic [PCW-1:0] mod_tab [NSEL];
    logic [PCW-1:0] base;
    logic [PCW-1:0] last;
    logic [PCW-1:0] pre_cnt;

    // One modulus per select value
    for (genvar g = 0; g < NSEL; g++) begin : g_mod
        assign mod_tab[g] = PCW'(1) << (P_LOG_MIN + g);
    end

    always_comb begin
        base = mod_tab[sel];
        // P+1 when swallowing: last count index equals P, else P-1
        last = swallow ? base : (base - PCW'(1));
        tick = (pre_cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PCW'(1);
        end
    end

endmodule

// File: rtl/pss_sequencer.sv
module pss_sequencer #(
    parameter int AW    = 6,
    parameter int BW    = 12,
    parameter int DEF_A = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] act_a,
    input  logic [BW-1:0] act_b,
    input  logic [AW-1:0] nxt_a,
    output logic          swallow,
    output logic          period_end,
    output logic [BW-1:0] b_index,
    output logic          div_pulse
);
    import pss_pkg::*;

    localparam phase_t RST_PHASE = (DEF_A != 0) ? ST_SWALLOW : ST_MAIN;

    phase_t        phase;
    phase_t        phase_nx;
    logic [AW-1:0] a_cnt;
    logic [BW-1:0] b_cnt;
    logic          a_done;

    always_comb begin
        period_end = tick && (b_cnt == (act_b - BW'(1)));
        a_done     = tick && (a_cnt == (act_a - AW'(1)));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= RST_PHASE;
        end else begin
            phase <= phase_nx;
        end
    end

    // Next-state logic: PERIOD_WRAP has priority over SWALLOW_DONE
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_SWALLOW: begin
                if (period_end) begin
                    phase_nx = (nxt_a != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (a_done) begin
                    phase_nx = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (period_end) begin
                    phase_nx = (nxt_a != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: phase_nx = RST_PHASE;
        endcase
    end

    // Swallow and main counters
    always_ff @(posedge clk) begin
        if (rst) begin
            a_cnt <= '0;
            b_cnt <= '0;
        end else if (period_end) begin
            a_cnt <= '0;
            b_cnt <= '0;
        end else if (tick) begin
            b_cnt <= b_cnt + BW'(1);
            if (phase == ST_SWALLOW) begin
                a_cnt <= a_cnt + AW'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= period_end;
        end
    end

    // Output decode
    always_comb begin
        swallow = (phase == ST_SWALLOW);
        b_index = b_cnt;
    end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int AW        = 6,
    parameter int BW        = 12,
    parameter int SW        = 2,
    parameter int P_LOG_MIN = 3,
    parameter int DEF_A     = 0,
    parameter int DEF_B     = 1,
    parameter int DEF_SEL   = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] cfg_a,
    input  logic [BW-1:0] cfg_b,
    input  logic [SW-1:0] cfg_sel,
    output logic          div_pulse,
    output logic          cfg_err
);
    logic [AW-1:0] act_a;
    logic [BW-1:0] act_b;
    logic [SW-1:0] act_sel;
    logic [AW-1:0] nxt_a;
    logic          swallow;
    logic          tick;
    logic          period_end;
    logic [BW-1:0] b_index;

    pss_cfg_gate #(
        .AW(AW), .BW(BW), .SW(SW),
        .DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_SEL(DEF_SEL)
    ) u_gate (
        .clk(clk), .rst(rst), .load(load),
        .in_a(cfg_a), .in_b(cfg_b), .in_sel(cfg_sel),
        .period_end(period_end),
        .act_a(act_a), .act_b(act_b), .act_sel(act_sel),
        .nxt_a(nxt_a), .cfg_err(cfg_err)
    );

    pss_prescaler #(
        .SW(SW), .P_LOG_MIN(P_LOG_MIN)
    ) u_pre (
        .clk(clk), .rst(rst), .swallow(swallow), .sel(act_sel), .tick(tick)
    );

    pss_sequencer #(
        .AW(AW), .BW(BW), .DEF_A(DEF_A)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick),
        .act_a(act_a), .act_b(act_b), .nxt_a(nxt_a),
        .swallow(swallow), .period_end(period_end),
        .b_index(b_index), .div_pulse(div_pulse)
    );

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int AW = 6,
    parameter int BW = 12,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic [AW-1:0] cfg_a,
    input logic [BW-1:0] cfg_b,
    input logic          div_pulse,
    input logic          cfg_err,
    input logic [AW-1:0] act_a,
    input logic [BW-1:0] act_b,
    input logic [SW-1:0] act_sel,
    input logic          swallow,
    input logic          period_end,
    input logic [BW-1:0] b_index
);
    logic bad_load;
    assign bad_load = (cfg_b == '0) || (BW'(cfg_a) > cfg_b);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);                                   // R3

    AST_BAD_LOAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (load && bad_load) |=> cfg_err);                             // R5

    AST_GOOD_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (load && !bad_load) |=> !cfg_err);                           // R6

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_err));                                 // R6

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (act_b != '0) && (BW'(act_a) <= act_b));                     // R5

    AST_ACTIVE_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable({act_a, act_b, act_sel}));           // R4

    AST_SWALLOW_FIRST: assert property (@(posedge clk) disable iff (rst)
        swallow |-> (b_index < BW'(act_a)));                         // R2

endmodule

bind pulse_swallow_div pss_checker #(.AW(AW), .BW(BW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .load(load), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .div_pulse(div_pulse), .cfg_err(cfg_err),
    .act_a(act_a), .act_b(act_b), .act_sel(act_sel),
    .swallow(swallow), .period_end(period_end), .b_index(b_index)
);

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [5:0]  cfg_a = '0;
    logic [11:0] cfg_b = '0;
    logic [1:0]  cfg_sel = '0;
    logic        div_pulse;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    int cur_n = 8;

    always #10 clk = ~clk;

    pulse_swallow_div uut (
        .clk(clk), .rst(rst), .load(load),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_sel(cfg_sel),
        .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    function automatic int exp_n(input int a, input int b, input int sel);
        return (8 << sel) * b + a;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling edges until div_pulse is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 10000);
    endtask

    // Drive a load for one cycle; uses one falling edge
    task automatic do_load(input int a, input int b, input int sel);
        cfg_a   = 6'(a);
        cfg_b   = 12'(b);
        cfg_sel = 2'(sel);
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pulse low after reset", int'(div_pulse), 0);
        chk("R1 err low after reset", int'(cfg_err), 0);
        n = 0;
        wait_pulse(n);
        chk("R1 first pulse delay", n, 8);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(div_pulse), 0);
        wait_pulse(n);
        chk("R1 default period", n + 1, 8);
        cur_n = 8;
    endtask

    task automatic t_setting(input int a, input int b, input int sel, input string tag);
        int n;
        int nn;
        nn = exp_n(a, b, sel);
        wait_pulse(n);
        do_load(a, b, sel);
        chk({tag, " R6 err low after good load"}, int'(cfg_err), 0);
        wait_pulse(n);
        chk({tag, " R4 running period kept"}, n + 1, cur_n);
        wait_pulse(n);
        chk({tag, " R2 new period"}, n, nn);
        @(negedge clk);
        chk({tag, " R3 pulse one cycle"}, int'(div_pulse), 0);
        wait_pulse(n);
        chk({tag, " R2 period repeats"}, n + 1, nn);
        cur_n = nn;
    endtask

    task automatic t_reject;
        int n;
        wait_pulse(n);
        do_load(5, 4, 0);
        chk("R5 err after A>B", int'(cfg_err), 1);
        wait_pulse(n);
        chk("R5 period unchanged after A>B", n + 1, cur_n);
        chk("R6 err holds without load", int'(cfg_err), 1);
        wait_pulse(n);
        chk("R5 period still unchanged", n, cur_n);
        do_load(0, 0, 1);
        chk("R5 err after B=0", int'(cfg_err), 1);
        // accepted then rejected in the same period: pending kept
        do_load(2, 3, 1);
        chk("R6 err cleared by good load", int'(cfg_err), 0);
        do_load(9, 3, 2);
        chk("R5 err after later bad load", int'(cfg_err), 1);
        wait_pulse(n);
        chk("R4 running period kept", n + 3, cur_n);
        wait_pulse(n);
        chk("R5 pending survives reject", n, exp_n(2, 3, 1));
        cur_n = exp_n(2, 3, 1);
    endtask

    task automatic t_last_wins;
        int n;
        wait_pulse(n);
        do_load(0, 3, 0);
        do_load(2, 3, 0);
        wait_pulse(n);
        chk("R7 running period kept", n + 2, cur_n);
        wait_pulse(n);
        chk("R7 last load applied", n, exp_n(2, 3, 0));
        cur_n = exp_n(2, 3, 0);
    endtask

    task automatic t_coincident;
        int n;
        int old_n;
        old_n = cur_n;
        wait_pulse(n);
        repeat (old_n - 1) @(negedge clk);
        cfg_a   = 6'd1;
        cfg_b   = 12'd2;
        cfg_sel = 2'd1;
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
        chk("R8 pulse on load edge", int'(div_pulse), 1);
        wait_pulse(n);
        chk("R8 next period uses old setting", n, old_n);
        wait_pulse(n);
        chk("R8 new setting one period later", n, exp_n(1, 2, 1));
        cur_n = exp_n(1, 2, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_setting(3, 5, 1, "A<B sel1");
        t_setting(0, 2, 0, "A=0 sel0");
        t_setting(7, 7, 2, "A=B sel2");
        t_setting(1, 1, 3, "A=B=1 sel3");
        t_setting(63, 63, 3, "max A=B sel3");
        t_reject();
        t_last_wins();
        t_coincident();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule